// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block turns one 32-bit instruction word of a small load/store RISC subset into everything a single-cycle datapath needs to execute it in the same cycle. It is purely combinational and has three outputs. The first is a 10-bit control word that steers the register-file destination, the jump and branch muxes, the data-memory strobes, the ALU operand source and the register write. The second is a 4-bit ALU function code. The third is the 32-bit extended immediate operand.

The supported operations are the register-format add, sub, and, or and slt, together with lw, sw, beq, bne, j, addi, andi, ori and lui. Immediate arithmetic and logic instructions use a third ALU-operation class, in which the opcode selects the ALU function instead of the funct field. The extension rule depends on the opcode. The logical immediates are padded with zeros. lui moves its constant into the upper half. All other instructions sign-extend. The register file, the memories and the PC update are outside this block.

Top module: `scd_decoder`

## Requirements
- R1: Control word bit positions (msb to lsb): 9 destination-from-rd, 8 jump, 7 branch, 6 memory read, 5 memory-to-register, 4 ALU-class high, 3 ALU-class low, 2 memory write, 1 ALU-operand-from-immediate, 0 register write. No word sets more than one of jump, branch, memory write and register write.
- R2: Opcode 0x00 (register format) gives control word 0x211.
- R3: Opcode 0x23 (lw) gives 0x063 and opcode 0x2B (sw) gives 0x006. Memory-to-register is only ever set together with memory read.
- R4: Opcodes 0x04 (beq) and 0x05 (bne) give 0x088, and the ALU function is subtract.
- R5: Opcode 0x02 (j) gives 0x100.
- R6: Opcodes 0x08 (addi), 0x0C (andi), 0x0D (ori) and 0x0F (lui) give 0x01B, with ALU class 11. The function comes from the opcode: add for addi and lui, and for andi, or for ori. The low six instruction bits have no effect.
- R7: ALU function codes are and=0x0, or=0x1, add=0x2, sub=0x6, slt=0x7. In register format, funct 0x20/0x22/0x24/0x25/0x2A select add/sub/and/or/slt, and any other funct selects add. ALU class 00 selects add.
- R8: For every opcode other than andi, ori and lui, the immediate output is bits 15:0 sign-extended (0xFFFC gives 0xFFFFFFFC).
- R9: andi and ori zero-extend bits 15:0, so the upper half is always zero.
- R10: lui outputs bits 15:0 in the upper half with zeros below (0x1000 gives 0x10000000).
- R11: Any opcode not listed above gives an all-zero control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word being executed |
| ctrl_o | output | 10 | Control word, layout per R1 |
| alu_fn_o | output | 4 | ALU function code per R7 |
| imm_o | output | 32 | Extended immediate operand |

## Verification
The assertions assume the instruction input is a settled, known 32-bit value whenever the decoder's outputs are evaluated. With no clock in the block, they only judge combinational results and never a transient between two instruction words. The bench keeps to this by changing the instruction only on the falling edge of its clock and sampling one nanosecond after the rising edge. Undefined opcodes and undefined funct codes are applied on purpose, because the requirements give their outputs.

// File: rtl/scd_pkg.sv
package scd_pkg;

    parameter int INSTR_W = 32;
    parameter int IMM_W   = 16;
    parameter int OP_W    = 6;
    parameter int FUNCT_W = 6;
    parameter int ALU_FN_W = 4;

    localparam int OP_LSB = INSTR_W - OP_W;

    // opcodes that the decoder recognises
    localparam logic [OP_W-1:0] OP_RFMT = 6'h00;
    localparam logic [OP_W-1:0] OP_JMP  = 6'h02;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'h04;
    localparam logic [OP_W-1:0] OP_BNE  = 6'h05;
    localparam logic [OP_W-1:0] OP_ADDI = 6'h08;
    localparam logic [OP_W-1:0] OP_ANDI = 6'h0C;
    localparam logic [OP_W-1:0] OP_ORI  = 6'h0D;
    localparam logic [OP_W-1:0] OP_LUI  = 6'h0F;
    localparam logic [OP_W-1:0] OP_LW   = 6'h23;
    localparam logic [OP_W-1:0] OP_SW   = 6'h2B;

    // register-format funct codes
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        ACLS_MEM  = 2'b00,
        ACLS_CMP  = 2'b01,
        ACLS_RFMT = 2'b10,
        ACLS_IMM  = 2'b11
    } alu_class_e;

    typedef enum logic [ALU_FN_W-1:0] {
        ALU_AND = 4'h0,
        ALU_OR  = 4'h1,
        ALU_ADD = 4'h2,
        ALU_SUB = 4'h6,
        ALU_SLT = 4'h7
    } alu_fn_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_mode_e;

    // field order is the bit order of the control word, msb first
    typedef struct packed {
        logic       dst_rd;
        logic       jump;
        logic       branch;
        logic       mem_rd;
        logic       mem_to_reg;
        alu_class_e alu_cls;
        logic       mem_wr;
        logic       src_imm;
        logic       reg_wr;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/scd_main_ctrl.sv
module scd_main_ctrl
    import scd_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    output ctrl_t           ctrl_o,
    output ext_mode_e       ext_o
);

    ctrl_t     ctrl_d;
    ext_mode_e ext_d;

    always_comb begin
        ctrl_d = '0;
        ext_d  = EXT_SIGN;
        unique case (opcode_i)
            OP_RFMT: begin
                ctrl_d.dst_rd  = 1'b1;
                ctrl_d.alu_cls = ACLS_RFMT;
                ctrl_d.reg_wr  = 1'b1;
            end
            OP_LW: begin
                ctrl_d.mem_rd     = 1'b1;
                ctrl_d.mem_to_reg = 1'b1;
                ctrl_d.alu_cls    = ACLS_MEM;
                ctrl_d.src_imm    = 1'b1;
                ctrl_d.reg_wr     = 1'b1;
            end
            OP_SW: begin
                ctrl_d.mem_wr  = 1'b1;
                ctrl_d.alu_cls = ACLS_MEM;
                ctrl_d.src_imm = 1'b1;
            end
            OP_BEQ, OP_BNE: begin
                ctrl_d.branch  = 1'b1;
                ctrl_d.alu_cls = ACLS_CMP;
            end
            OP_JMP: begin
                ctrl_d.jump = 1'b1;
            end
            OP_ADDI, OP_ANDI, OP_ORI, OP_LUI: begin
                ctrl_d.alu_cls = ACLS_IMM;
                ctrl_d.src_imm = 1'b1;
                ctrl_d.reg_wr  = 1'b1;
                if (opcode_i == OP_ANDI || opcode_i == OP_ORI)
                    ext_d = EXT_ZERO;
                else if (opcode_i == OP_LUI)
                    ext_d = EXT_UPPER;
            end
            default: ctrl_d = '0;
        endcase
    end

    assign ctrl_o = ctrl_d;
    assign ext_o  = ext_d;

    // a_r1_one_action: at most one of jump/branch/store/register write
    always_comb begin
        a_r1_one_action: assert ($onehot0({ctrl_d.jump, ctrl_d.branch,
                                           ctrl_d.mem_wr, ctrl_d.reg_wr}))
            else $error("R1 more than one action in control word");
    end

endmodule

// File: rtl/scd_alu_sel.sv
module scd_alu_sel
    import scd_pkg::*;
(
    input  alu_class_e         cls_i,
    input  logic [OP_W-1:0]    opcode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output alu_fn_e            fn_o
);

    alu_fn_e fn_d;

    always_comb begin
        fn_d = ALU_ADD;
        unique case (cls_i)
            ACLS_MEM: fn_d = ALU_ADD;
            ACLS_CMP: fn_d = ALU_SUB;
            ACLS_RFMT: begin
                unique case (funct_i)
                    FN_ADD:  fn_d = ALU_ADD;
                    FN_SUB:  fn_d = ALU_SUB;
                    FN_AND:  fn_d = ALU_AND;
                    FN_OR:   fn_d = ALU_OR;
                    FN_SLT:  fn_d = ALU_SLT;
                    default: fn_d = ALU_ADD;
                endcase
            end
            ACLS_IMM: begin
                unique case (opcode_i)
                    OP_ANDI: fn_d = ALU_AND;
                    OP_ORI:  fn_d = ALU_OR;
                    default: fn_d = ALU_ADD;
                endcase
            end
            default: fn_d = ALU_ADD;
        endcase
    end

    assign fn_o = fn_d;

endmodule

// File: rtl/scd_imm_ext.sv
module scd_imm_ext
    import scd_pkg::*;
(
    input  ext_mode_e          mode_i,
    input  logic [IMM_W-1:0]   imm_i,
    output logic [INSTR_W-1:0] imm_o
);

    localparam int PAD_W = INSTR_W - IMM_W;

    logic [INSTR_W-1:0] imm_d;

    always_comb begin
        unique case (mode_i)
            EXT_ZERO:  imm_d = {{PAD_W{1'b0}}, imm_i};
            EXT_UPPER: imm_d = {imm_i, {PAD_W{1'b0}}};
            default:   imm_d = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
        endcase
    end

    assign imm_o = imm_d;

endmodule

// File: rtl/scd_decoder.sv
module scd_decoder
    import scd_pkg::*;
(
    input  logic [INSTR_W-1:0]  instr_i,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [ALU_FN_W-1:0] alu_fn_o,
    output logic [INSTR_W-1:0]  imm_o
);

    logic [OP_W-1:0]    opcode;
    logic [FUNCT_W-1:0] funct;
    logic [IMM_W-1:0]   imm_raw;
    ctrl_t              ctrl;
    ext_mode_e          ext_mode;
    alu_fn_e            alu_fn;
    logic               unused_fields;

    assign opcode  = instr_i[INSTR_W-1:OP_LSB];
    assign funct   = instr_i[FUNCT_W-1:0];
    assign imm_raw = instr_i[IMM_W-1:0];
    assign unused_fields = ^instr_i[OP_LSB-1:IMM_W];

    scd_main_ctrl u_main_ctrl (
        .opcode_i (opcode),
        .ctrl_o   (ctrl),
        .ext_o    (ext_mode)
    );

    scd_alu_sel u_alu_sel (
        .cls_i    (ctrl.alu_cls),
        .opcode_i (opcode),
        .funct_i  (funct),
        .fn_o     (alu_fn)
    );

    scd_imm_ext u_imm_ext (
        .mode_i (ext_mode),
        .imm_i  (imm_raw),
        .imm_o  (imm_o)
    );

    assign ctrl_o   = ctrl;
    assign alu_fn_o = alu_fn;

    // checks across the sub-blocks
    always_comb begin
        // R4: a branch always drives a subtract
        a_r4_branch_sub: assert (!ctrl.branch || alu_fn == ALU_SUB)
            else $error("R4 branch without subtract");
        // R3: memory-to-register only with a memory read
        a_r3_load_pair: assert (!ctrl.mem_to_reg || ctrl.mem_rd)
            else $error("R3 mem_to_reg without mem_rd");
        // R6: immediate class always takes the immediate operand and writes
        a_r6_imm_class: assert (ctrl.alu_cls != ACLS_IMM || (ctrl.src_imm && ctrl.reg_wr))
            else $error("R6 immediate class incomplete");
        // R9: logical immediates carry a zero upper half
        a_r9_zero_upper: assert (!(opcode == OP_ANDI || opcode == OP_ORI)
                                 || imm_o[INSTR_W-1:IMM_W] == '0)
            else $error("R9 upper half not zero");
        // R10: lui leaves the lower half clear
        a_r10_lui_low: assert (opcode != OP_LUI || imm_o[IMM_W-1:0] == '0)
            else $error("R10 lower half not zero");
        // R11: unknown opcodes leave every control bit low
        a_r11_unknown_zero: assert (!(opcode inside {6'h01, 6'h03, 6'h3F}) || ctrl_o == '0)
            else $error("R11 control word not zero");
    end

endmodule

// File: tb/scd_decoder_bench.sv
`timescale 1ns/1ps
module scd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr;
    logic [9:0]  ctrl;
    logic [3:0]  fn;
    logic [31:0] imm;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    scd_decoder u_scd_decoder (
        .instr_i  (instr),
        .ctrl_o   (ctrl),
        .alu_fn_o (fn),
        .imm_o    (imm)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [9:0]  ctrl;
        logic [3:0]  fn;
        logic [31:0] imm;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h00003020, 10'h211, 4'h2, 32'h00003020, 4'd2},  // R2 add
        '{32'h00822822, 10'h211, 4'h6, 32'h00002822, 4'd7},  // R7 sub
        '{32'h00431024, 10'h211, 4'h0, 32'h00001024, 4'd7},  // R7 and
        '{32'h00431025, 10'h211, 4'h1, 32'h00001025, 4'd7},  // R7 or
        '{32'h0043102A, 10'h211, 4'h7, 32'h0000102A, 4'd7},  // R7 slt
        '{32'h00000003, 10'h211, 4'h2, 32'h00000003, 4'd7},  // R7 unknown funct
        '{32'h8cc7fffc, 10'h063, 4'h2, 32'hFFFFFFFC, 4'd3},  // R3 lw, R8
        '{32'hacc20008, 10'h006, 4'h2, 32'h00000008, 4'd3},  // R3 sw
        '{32'h1062ffee, 10'h088, 4'h6, 32'hFFFFFFEE, 4'd4},  // R4 beq
        '{32'h1443ffff, 10'h088, 4'h6, 32'hFFFFFFFF, 4'd4},  // R4 bne
        '{32'h08100000, 10'h100, 4'h2, 32'h00000000, 4'd5},  // R5 j
        '{32'h20c60003, 10'h01B, 4'h2, 32'h00000003, 4'd6},  // R6 addi
        '{32'h20038000, 10'h01B, 4'h2, 32'hFFFF8000, 4'd8},  // R8 addi negative
        '{32'h30e0ffff, 10'h01B, 4'h0, 32'h0000FFFF, 4'd9},  // R9 andi
        '{32'h34029111, 10'h01B, 4'h1, 32'h00009111, 4'd9},  // R9 ori
        '{32'h3c061000, 10'h01B, 4'h2, 32'h10000000, 4'd10}, // R10 lui
        '{32'hFC000000, 10'h000, 4'h2, 32'h00000000, 4'd11}  // R11 unknown opcode
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string tag, input logic [9:0] ec,
                             input logic [3:0] ef, input logic [31:0] ei);
        check({tag, " ctrl"}, {22'd0, ctrl}, {22'd0, ec});
        check({tag, " fn"},   {28'd0, fn},   {28'd0, ef});
        check({tag, " imm"},  imm,           ei);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        instr = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        // reset state: all-zero word decodes as register format, unknown funct (R2, R7)
        check_all("R2 reset word", 10'h211, 4'h2, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].ins);
            check_all($sformatf("R%0d vector %0d", VECS[i].req, i),
                      VECS[i].ctrl, VECS[i].fn, VECS[i].imm);
        end

        // R1: bit positions of lw word, one bit at a time
        apply(32'h8cc7fffc);
        check("R1 mem read bit6", {31'd0, ctrl[6]}, 32'd1);
        check("R1 mem_to_reg bit5", {31'd0, ctrl[5]}, 32'd1);
        check("R1 class bits4:3", {30'd0, ctrl[4:3]}, 32'd0);

        // R6: funct-like low bits ignored for immediate ops
        apply(32'h20000022);
        check_all("R6 addi low bits 0x22", 10'h01B, 4'h2, 32'h00000022);
        apply(32'h3000002A);
        check_all("R6 andi low bits 0x2A", 10'h01B, 4'h0, 32'h0000002A);
        apply(32'h34000024);
        check_all("R6 ori low bits 0x24", 10'h01B, 4'h1, 32'h00000024);

        // R10: lui upper with all ones
        apply(32'h3c00FFFF);
        check_all("R10 lui ffff", 10'h01B, 4'h2, 32'hFFFF0000);

        // R8: sw with negative offset, R9: ori with sign bit set
        apply(32'hac008000);
        check_all("R8 sw negative", 10'h006, 4'h2, 32'hFFFF8000);
        apply(32'h34008000);
        check_all("R9 ori bit15", 10'h01B, 4'h1, 32'h00008000);

        // R11: other unused opcodes
        apply(32'h04000025);
        check_all("R11 opcode 01", 10'h000, 4'h2, 32'h00000025);
        apply(32'h0C000000);
        check_all("R11 opcode 03", 10'h000, 4'h2, 32'h00000000);

        // R2: register fields do not change the decode
        apply(32'h03FFF820);
        check_all("R2 all regs set", 10'h211, 4'h2, 32'hFFFFF820);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule